// File: doc/BRIEF.md
# Dual-Bank Video Memory with Split CPU and Renderer Ports

This block holds video memory as two byte-wide banks that answer to the same address window. A processor-side port reads and writes one bank at a time; which one is decided by bit 0 of a bank-select register mapped at I/O address 0xFF4F. A second, read-only port serves the pixel renderer. It returns the byte at the requested offset from both banks in the same response, whatever the processor has selected. Bank 0 carries tile patterns and the tile map. Bank 1 carries a second set of tile patterns and the per-tile attribute bytes.

A mode input chooses between colour operation, where both banks exist, and legacy operation, where only bank 0 exists. In legacy operation the processor always reaches bank 0, writes to the select bit are dropped, and the renderer's bank-1 output reads as 0xFF. The window starts at `WIN_BASE` and spans 2^`WIN_AW` bytes per bank. Full size is 0x8000 to 0x9FFF with `WIN_AW` = 13. The default of 11 keeps elaboration small.

Both request paths are valid-only streams. The block never applies back-pressure: every request is accepted in the cycle it is presented. Each read produces exactly one response, flagged by its own valid, one clock later. A response cannot be stalled, so the consumer must take it in that cycle.

Top module: `dual_bank_vram`

## Requirements
- R1: A processor write inside the window stores the byte in the currently effective bank at offset (address − WIN_BASE). A processor write outside the window, other than to 0xFF4F, changes no stored byte.
- R2: In colour mode (`colour_mode`=1), writing 0xFF4F loads bit 0 of the data into the bank select. Reading 0xFF4F returns 7'b1111111 in bits 7..1 and the select in bit 0.
- R3: After reset the bank select is 0, so a read of 0xFF4F returns 0xFE.
- R4: In legacy mode (`colour_mode`=0), writes to 0xFF4F leave the stored select unchanged. Processor accesses go to bank 0 whatever the stored select is. Reads of 0xFF4F return 0xFE.
- R5: A renderer request returns bank 0's byte on `pix_data0` and bank 1's byte on `pix_data1` for the same offset. Both are returned regardless of the bank select, with `pix_rsp_valid` high exactly one clock after `pix_req_valid`.
- R6: A renderer request whose address lies outside the window returns 0xFF on both data outputs.
- R7: In legacy mode, sampled at request time, `pix_data1` returns 0xFF and `pix_data0` returns bank 0's byte.
- R8: A processor read (`cpu_sel`=1, `cpu_we`=0) raises `cpu_rvalid` exactly one clock later with the data. Addresses that are neither in the window nor 0xFF4F read as 0xFF.
- R9: When a renderer read and a processor write hit the same location in the same cycle, the renderer receives the old byte. The next read returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| colour_mode | input | 1 | 1 = two banks, 0 = legacy single bank |
| cpu_sel | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rvalid | output | 1 | Processor read response valid |
| cpu_rdata | output | 8 | Processor read data |
| pix_req_valid | input | 1 | Renderer read request valid |
| pix_addr | input | 16 | Renderer byte address |
| pix_rsp_valid | output | 1 | Renderer response valid |
| pix_data0 | output | 8 | Byte from bank 0 |
| pix_data1 | output | 8 | Byte from bank 1 (0xFF in legacy mode) |

## Verification
Every result of this block is due exactly one clock after its request: processor read data, select-register reads and both renderer bytes. A write to the select register or a bank takes effect for any request presented in the following cycle. The bench drives each request on a falling edge and clears it on the next falling edge. It reads the response there, half a period after the rising edge that registered it, and never earlier. The same-cycle read/write collision case is driven in a single request cycle and then read back one cycle later to confirm the stored value changed.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef logic [15:0] vaddr_t;
  typedef logic [7:0]  vbyte_t;

  localparam int     NUM_BANKS = 2;
  localparam vbyte_t UNMAPPED  = 8'hFF;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_MEM  = 2'd1,
    RSP_REG  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/vram_addr_dec.sv
module vram_addr_dec
  import vram_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h8000,
  parameter int          WIN_AW   = 11
) (
  input  vaddr_t             addr,
  output logic               hit,
  output logic [WIN_AW-1:0]  offset
);
  localparam logic [16:0] LO = {1'b0, WIN_BASE};
  localparam logic [16:0] HI = LO + 17'((1 << WIN_AW) - 1);

  logic [16:0] wide;
  assign wide   = {1'b0, addr};
  assign hit    = (wide >= LO) && (wide <= HI);
  assign offset = WIN_AW'(addr - WIN_BASE);
endmodule

// File: rtl/vram_bank_sel.sv
module vram_bank_sel
  import vram_pkg::*;
#(
  parameter logic [15:0] SEL_ADDR = 16'hFF4F
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   colour_en,
  input  logic   cpu_sel,
  input  logic   cpu_we,
  input  vaddr_t cpu_addr,
  input  logic   wbit,
  output logic   reg_hit,
  output logic   eff_bank,
  output vbyte_t reg_rdata
);
  logic sel_q;
  logic wr_hit;

  assign reg_hit = (cpu_addr == SEL_ADDR);
  assign wr_hit  = cpu_sel && cpu_we && reg_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= 1'b0;
    else if (wr_hit && colour_en)
      sel_q <= wbit;
  end

  assign eff_bank  = colour_en & sel_q;
  assign reg_rdata = {7'h7F, eff_bank};

  // R4
  legacy_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !colour_en) |=> (sel_q == $past(sel_q)));

  // R2
  colour_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && colour_en) |=> (sel_q == $past(wbit)));
endmodule

// File: rtl/vram_bank.sv
module vram_bank
  import vram_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  vbyte_t        wdata,
  input  logic [AW-1:0] a_addr,
  output vbyte_t        a_rdata,
  input  logic [AW-1:0] b_addr,
  output vbyte_t        b_rdata
);
  localparam int DEPTH = 1 << AW;

  vbyte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/dual_bank_vram.sv
module dual_bank_vram
  import vram_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h8000,
  parameter int          WIN_AW   = 11,
  parameter logic [15:0] SEL_ADDR = 16'hFF4F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        colour_mode,
  input  logic        cpu_sel,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic        cpu_rvalid,
  output logic [7:0]  cpu_rdata,
  input  logic        pix_req_valid,
  input  logic [15:0] pix_addr,
  output logic        pix_rsp_valid,
  output logic [7:0]  pix_data0,
  output logic [7:0]  pix_data1
);
  logic              cpu_hit, pix_hit;
  logic [WIN_AW-1:0] cpu_off, pix_off;
  logic              reg_hit, eff_bank;
  vbyte_t            reg_rdata;

  vbyte_t a_rd [NUM_BANKS];
  vbyte_t b_rd [NUM_BANKS];

  vram_addr_dec #(.WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW)) u_cpu_dec (
    .addr(cpu_addr), .hit(cpu_hit), .offset(cpu_off)
  );

  vram_addr_dec #(.WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW)) u_pix_dec (
    .addr(pix_addr), .hit(pix_hit), .offset(pix_off)
  );

  vram_bank_sel #(.SEL_ADDR(SEL_ADDR)) u_sel (
    .clk(clk), .rst_n(rst_n), .colour_en(colour_mode),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .wbit(cpu_wdata[0]), .reg_hit(reg_hit), .eff_bank(eff_bank),
    .reg_rdata(reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = cpu_sel && cpu_we && cpu_hit && (int'(eff_bank) == b);

    vram_bank #(.AW(WIN_AW)) u_mem (
      .clk(clk), .we(bank_we), .waddr(cpu_off), .wdata(cpu_wdata),
      .a_addr(cpu_off), .a_rdata(a_rd[b]),
      .b_addr(pix_off), .b_rdata(b_rd[b])
    );
  end

  // processor response pipeline
  rsp_kind_e cpu_kind_q;
  logic      cpu_bank_q;
  vbyte_t    reg_q;
  logic      cpu_rvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rvalid_q <= 1'b0;
      cpu_kind_q   <= RSP_NONE;
      cpu_bank_q   <= 1'b0;
      reg_q        <= UNMAPPED;
    end else begin
      cpu_rvalid_q <= cpu_sel && !cpu_we;
      cpu_bank_q   <= eff_bank;
      reg_q        <= reg_rdata;
      if (cpu_hit)      cpu_kind_q <= RSP_MEM;
      else if (reg_hit) cpu_kind_q <= RSP_REG;
      else              cpu_kind_q <= RSP_NONE;
    end
  end

  assign cpu_rvalid = cpu_rvalid_q;

  always_comb begin
    unique case (cpu_kind_q)
      RSP_MEM: cpu_rdata = a_rd[cpu_bank_q];
      RSP_REG: cpu_rdata = reg_q;
      default: cpu_rdata = UNMAPPED;
    endcase
  end

  // renderer response pipeline
  logic pix_valid_q, pix_hit_q, pix_colour_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid_q  <= 1'b0;
      pix_hit_q    <= 1'b0;
      pix_colour_q <= 1'b0;
    end else begin
      pix_valid_q  <= pix_req_valid;
      pix_hit_q    <= pix_hit;
      pix_colour_q <= colour_mode;
    end
  end

  assign pix_rsp_valid = pix_valid_q;
  assign pix_data0     = pix_hit_q ? b_rd[0] : UNMAPPED;
  assign pix_data1     = (pix_hit_q && pix_colour_q) ? b_rd[1] : UNMAPPED;

  // R8
  cpu_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid == $past(cpu_sel && !cpu_we));

  // R5
  pix_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rsp_valid == $past(pix_req_valid));

  // R6
  pix_out_of_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rsp_valid && !$past(pix_hit)) |-> (pix_data0 == 8'hFF && pix_data1 == 8'hFF));

  // R7
  pix_legacy_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rsp_valid && !$past(colour_mode)) |-> (pix_data1 == 8'hFF));
endmodule

// File: tb/dual_bank_vram_test.sv
module dual_bank_vram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] BASE = 16'h8000;
  localparam logic [15:0] SELA = 16'hFF4F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        colour_mode = 1'b0;
  logic        cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [7:0]  cpu_rdata;
  logic        pix_req_valid = 1'b0;
  logic [15:0] pix_addr = '0;
  logic        pix_rsp_valid;
  logic [7:0]  pix_data0, pix_data1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_vram #(.WIN_BASE(BASE), .WIN_AW(AW), .SEL_ADDR(SELA)) uut (
    .clk(clk), .rst_n(rst_n), .colour_mode(colour_mode),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .pix_req_valid(pix_req_valid), .pix_addr(pix_addr),
    .pix_rsp_valid(pix_rsp_valid), .pix_data0(pix_data0), .pix_data1(pix_data1)
  );

  function automatic logic [7:0] pattern(int bank, int off);
    return 8'((off * 7 + bank * 93 + (off >> 8)) & 255);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(string req, logic [15:0] a, logic [7:0] exp);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_sel = 1'b0;
    chk(req, {7'b0, cpu_rvalid}, 8'd1);
    chk(req, cpu_rdata, exp);
  endtask

  task automatic pix_read(string req, logic [15:0] a, logic [7:0] e0, logic [7:0] e1);
    @(negedge clk);
    pix_req_valid = 1'b1; pix_addr = a;
    @(negedge clk);
    pix_req_valid = 1'b0;
    chk(req, {7'b0, pix_rsp_valid}, 8'd1);
    chk(req, pix_data0, e0);
    chk(req, pix_data1, e1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // reset state
    chk("R3 rvalid idle", {7'b0, cpu_rvalid}, 8'd0);
    chk("R5 pix idle", {7'b0, pix_rsp_valid}, 8'd0);
    rst_n = 1'b1;
    colour_mode = 1'b1;
    cpu_read("R3 select after reset", SELA, 8'hFE);

    // R1 R2: fill both banks through the processor port
    cpu_write(SELA, 8'h00);
    cpu_read("R2 select=0 read", SELA, 8'hFE);
    for (int i = 0; i < DEPTH; i++) cpu_write(BASE + 16'(i), pattern(0, i));
    cpu_write(SELA, 8'hFF);
    cpu_read("R2 select=1 read", SELA, 8'hFF);
    for (int i = 0; i < DEPTH; i++) cpu_write(BASE + 16'(i), pattern(1, i));

    // R5: renderer sees both banks, select currently 1
    for (int i = 0; i < DEPTH; i++)
      pix_read("R5 dual read", BASE + 16'(i), pattern(0, i), pattern(1, i));

    // R1 R8: processor reads follow the select
    for (int i = 0; i < DEPTH; i += 97) cpu_read("R1 bank1 read", BASE + 16'(i), pattern(1, i));
    cpu_write(SELA, 8'h02);  // bit 0 clear -> bank 0
    for (int i = 0; i < DEPTH; i += 97) cpu_read("R1 bank0 read", BASE + 16'(i), pattern(0, i));
    pix_read("R5 select-independent", BASE + 16'd5, pattern(0, 5), pattern(1, 5));

    // R6 R8 R1: out-of-window accesses
    pix_read("R6 below window", BASE - 16'd1, 8'hFF, 8'hFF);
    pix_read("R6 above window", BASE + 16'(DEPTH), 8'hFF, 8'hFF);
    pix_read("R6 zero", 16'h0000, 8'hFF, 8'hFF);
    pix_read("R6 top", 16'hFFFF, 8'hFF, 8'hFF);
    cpu_read("R8 unmapped read", 16'h1234, 8'hFF);
    cpu_read("R8 above window read", BASE + 16'(DEPTH), 8'hFF);
    cpu_write(BASE + 16'(DEPTH), 8'h5A);  // would alias offset 0 without range check
    cpu_write(BASE - 16'd1, 8'h5A);
    pix_read("R1 stray write ignored", BASE, pattern(0, 0), pattern(1, 0));
    pix_read("R1 stray write ignored top", BASE + 16'(DEPTH - 1),
             pattern(0, DEPTH - 1), pattern(1, DEPTH - 1));

    // R9: same-cycle renderer read and processor write
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = BASE + 16'd9; cpu_wdata = 8'hC3;
    pix_req_valid = 1'b1; pix_addr = BASE + 16'd9;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0; pix_req_valid = 1'b0;
    chk("R9 old byte returned", pix_data0, pattern(0, 9));
    pix_read("R9 new byte visible", BASE + 16'd9, 8'hC3, pattern(1, 9));

    // R4 R7: legacy mode with stored select = 1
    cpu_write(SELA, 8'h01);
    colour_mode = 1'b0;
    cpu_read("R4 select reads FE", SELA, 8'hFE);
    cpu_read("R4 cpu sees bank0", BASE + 16'd20, pattern(0, 20));
    for (int i = 0; i < DEPTH; i += 61)
      pix_read("R7 legacy renderer", BASE + 16'(i), (i == 9) ? 8'hC3 : pattern(0, i), 8'hFF);
    cpu_write(BASE + 16'd30, 8'h77);
    colour_mode = 1'b1;
    pix_read("R4 legacy write to bank0", BASE + 16'd30, 8'h77, pattern(1, 30));
    // legacy select write ignored
    cpu_write(SELA, 8'h00);
    colour_mode = 1'b0;
    cpu_write(SELA, 8'h01);
    colour_mode = 1'b1;
    cpu_read("R4 legacy select write ignored", SELA, 8'hFE);
    cpu_read("R4 still bank0", BASE + 16'd40, pattern(0, 40));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule